// File: doc/BRIEF.md
# Reorder Buffer with In-Entry Result Renaming

This block tracks in-flight operations from the moment they are allocated until they retire, and it also renames the eight 32-bit architectural registers. Each slot of a circular buffer carries its own result field. A completed operation writes its result into its slot, and that slot serves as the rename register. No separate pool of physical registers exists. A small committed register file holds the retired value of each architectural register, and its entries are never handed out as rename targets.

A front end allocates one operation per cycle. It gives the destination register and two source registers, and it receives the slot tag. For each source it also receives either a ready value or the tag of the slot that will produce the value. Execution units may finish in any order, and they return tag and result through the write-back port. Retirement is strictly in program order from the oldest slot. A retiring slot copies its result into the committed file. A flush input discards everything in flight and points every register back at the committed file.

Top module: `rob_rename`

## Requirements
- R1: After reset, `rob_empty` and `alloc_ready` are 1, `alloc_ack` and `retire_valid` are 0, and every committed register reads 0.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both 1 and `flush` is 0. One cycle later `alloc_ack` is 1 and `alloc_tag` gives the slot. Slots are handed out in sequence 0, 1, …, DEPTH-1 and then wrap to 0.
- R3: When DEPTH slots are in flight, `alloc_ready` is 0 and a request produces no `alloc_ack`.
- R4: A source register that has no in-flight producer returns `srcN_ready`=1, and `srcN_val` holds its committed value.
- R5: A source register whose youngest in-flight producer has not completed returns `srcN_ready`=0, and `srcN_val` holds that producer's tag, zero-extended.
- R6: A source register whose youngest producer has completed returns that slot's result with ready=1. This also applies when the producer's write-back arrives in the same cycle as the allocation.
- R7: The oldest slot retires only once its result has been written back. Younger slots that complete earlier wait behind it.
- R8: One cycle after a retirement, `retire_valid` is 1, and `retire_reg` and `retire_data` give the destination and result of the retiring slot. The committed file then holds that value. The register's mapping is dropped only if no younger in-flight writer of that register exists.
- R9: An allocation and a retirement in the same cycle both take effect, and the occupancy does not change.
- R10: A flush empties the buffer (`rob_empty`=1 one cycle later), and from then on every source lookup returns the committed value. An allocation in the flush cycle is not accepted.
- R11: When two in-flight operations write the same register and the younger one completes first, later readers see the younger result. Once both have retired, the committed file holds the younger result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all in-flight operations |
| alloc_valid | input | 1 | Allocation request |
| alloc_dst | input | 3 | Destination register of the new operation |
| alloc_src0 | input | 3 | First source register |
| alloc_src1 | input | 3 | Second source register |
| alloc_ready | output | 1 | Buffer has a free slot |
| alloc_ack | output | 1 | Registered: an allocation was accepted last cycle |
| alloc_tag | output | 7 | Slot given to the accepted operation |
| src0_ready | output | 1 | First source value is available |
| src0_val | output | 32 | First source value, or producer tag when not ready |
| src1_ready | output | 1 | Second source value is available |
| src1_val | output | 32 | Second source value, or producer tag when not ready |
| wb_valid | input | 1 | Write-back strobe |
| wb_tag | input | 7 | Slot being completed |
| wb_data | input | 32 | Result for that slot |
| retire_valid | output | 1 | Registered: a slot retired last cycle |
| retire_reg | output | 3 | Destination of the retired slot |
| retire_data | output | 32 | Result of the retired slot |
| rob_empty | output | 1 | No operation in flight |

## Verification
The bench keeps its own model of the slots, the rename map and the committed file. It predicts every acknowledgement, operand and retirement from that model. Directed sequences check specific orderings. Lookup against an unmapped register and against a pending producer tells the committed-value path apart from the tag path. Write-back of a younger slot before the oldest one tells in-order retirement apart from completion order. A write-back that coincides with a consumer's allocation exercises the bypass. Two writers of one register completed in reverse order separate correct mapping release from a premature clear. Filling to DEPTH and then flushing covers the full stall and the reset of the map. Long stretches of seeded random traffic then mix allocation, scattered write-back and occasional flushes.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // how an allocation-time source lookup was resolved
  typedef enum logic [1:0] {
    SRC_COMMITTED = 2'd0,
    SRC_SLOT      = 2'd1,
    SRC_BYPASS    = 2'd2,
    SRC_PENDING   = 2'd3
  } src_kind_e;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/rob_rename_table.sv
module rob_rename_table #(
  parameter int NREG = 8,
  parameter int XLEN = 32,
  parameter int TAGW = 7,
  parameter int NRD  = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic [NRD-1:0][RW-1:0]    rd_reg,
  output logic [NRD-1:0]            rd_mapped,
  output logic [NRD-1:0][TAGW-1:0]  rd_tag,
  output logic [NRD-1:0][XLEN-1:0]  rd_value,
  input  logic                      set_we,
  input  logic [RW-1:0]             set_reg,
  input  logic [TAGW-1:0]           set_tag,
  input  logic                      ret_we,
  input  logic [RW-1:0]             ret_reg,
  input  logic [TAGW-1:0]           ret_tag,
  input  logic [XLEN-1:0]           ret_data
);
  logic [NREG-1:0]           map_vld;
  logic [TAGW-1:0]           map_tag [NREG];
  logic [XLEN-1:0]           committed [NREG];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_mapped[p] = map_vld[rd_reg[p]];
    assign rd_tag[p]    = map_tag[rd_reg[p]];
    assign rd_value[p]  = committed[rd_reg[p]];
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        map_vld[r]   <= 1'b0;
        map_tag[r]   <= '0;
        committed[r] <= '0;
      end else if (flush) begin
        map_vld[r] <= 1'b0;
      end else begin
        if (ret_we && ret_reg == RW'(r))
          committed[r] <= ret_data;
        if (set_we && set_reg == RW'(r)) begin
          map_vld[r] <= 1'b1;
          map_tag[r] <= set_tag;
        end else if (ret_we && ret_reg == RW'(r) && map_vld[r] && map_tag[r] == ret_tag) begin
          map_vld[r] <= 1'b0;
        end
      end
    end
  end

  // R10
  map_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (map_vld == '0));

  // R8
  ret_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_we && !flush) |=> (committed[$past(ret_reg)] == $past(ret_data)));
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH = 72,
  parameter int XLEN  = 32,
  parameter int RW    = 3,
  parameter int NRD   = 2,
  localparam int TAGW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc_we,
  input  logic [TAGW-1:0]           alloc_idx,
  input  logic [RW-1:0]             alloc_dst,
  input  logic                      wb_we,
  input  logic [TAGW-1:0]           wb_idx,
  input  logic [XLEN-1:0]           wb_data,
  input  logic [TAGW-1:0]           head_idx,
  output logic                      head_done,
  output logic [RW-1:0]             head_dst,
  output logic [XLEN-1:0]           head_data,
  input  logic [NRD-1:0][TAGW-1:0]  q_idx,
  output logic [NRD-1:0]            q_done,
  output logic [NRD-1:0][XLEN-1:0]  q_data
);
  logic [DEPTH-1:0] done_q;
  logic [RW-1:0]    dst_mem  [DEPTH];
  logic [XLEN-1:0]  data_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
    end else begin
      if (alloc_we) done_q[alloc_idx] <= 1'b0;
      if (wb_we)    done_q[wb_idx]    <= 1'b1;
    end
  end

  // result field: one write port, plain array with no reset
  always_ff @(posedge clk) begin
    if (wb_we) data_mem[wb_idx] <= wb_data;
  end

  always_ff @(posedge clk) begin
    if (alloc_we) dst_mem[alloc_idx] <= alloc_dst;
  end

  assign head_done = done_q[head_idx];
  assign head_dst  = dst_mem[head_idx];
  assign head_data = data_mem[head_idx];

  for (genvar p = 0; p < NRD; p++) begin : g_q
    assign q_done[p] = done_q[q_idx[p]];
    assign q_data[p] = data_mem[q_idx[p]];
  end

  // R6
  wb_alloc_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_we && wb_we) |-> (alloc_idx != wb_idx));

  // R6
  wb_marks_done_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_we && !(alloc_we && alloc_idx == wb_idx)) |=> done_q[$past(wb_idx)]);
endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int DEPTH = 72,
  parameter int NREG  = 8,
  parameter int XLEN  = 32,
  localparam int TAGW = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            alloc_valid,
  input  logic [RW-1:0]   alloc_dst,
  input  logic [RW-1:0]   alloc_src0,
  input  logic [RW-1:0]   alloc_src1,
  output logic            alloc_ready,
  output logic            alloc_ack,
  output logic [TAGW-1:0] alloc_tag,
  output logic            src0_ready,
  output logic [XLEN-1:0] src0_val,
  output logic            src1_ready,
  output logic [XLEN-1:0] src1_val,
  input  logic            wb_valid,
  input  logic [TAGW-1:0] wb_tag,
  input  logic [XLEN-1:0] wb_data,
  output logic            retire_valid,
  output logic [RW-1:0]   retire_reg,
  output logic [XLEN-1:0] retire_data,
  output logic            rob_empty
);
  import rob_pkg::*;

  logic [TAGW-1:0] head, tail;
  logic [CW-1:0]   count;

  logic alloc_fire, ret_fire, wb_fire;
  logic head_done;
  logic [RW-1:0]   head_dst;
  logic [XLEN-1:0] head_data;

  logic [NUM_SRC-1:0][RW-1:0]   src_reg;
  logic [NUM_SRC-1:0]           map_hit;
  logic [NUM_SRC-1:0][TAGW-1:0] map_tag;
  logic [NUM_SRC-1:0][XLEN-1:0] arch_val;
  logic [NUM_SRC-1:0]           slot_done;
  logic [NUM_SRC-1:0][XLEN-1:0] slot_data;
  logic [NUM_SRC-1:0]           op_rdy;
  logic [NUM_SRC-1:0][XLEN-1:0] op_val;
  src_kind_e                    op_kind [NUM_SRC];

  function automatic logic [TAGW-1:0] bump(input logic [TAGW-1:0] p);
    return (p == TAGW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign alloc_ready = (count != CW'(DEPTH));
  assign rob_empty   = (count == '0);
  assign alloc_fire  = alloc_valid && alloc_ready && !flush;
  assign ret_fire    = !flush && !rob_empty && head_done;
  assign wb_fire     = wb_valid && !flush;

  assign src_reg[0] = alloc_src0;
  assign src_reg[1] = alloc_src1;

  rob_rename_table #(.NREG(NREG), .XLEN(XLEN), .TAGW(TAGW), .NRD(NUM_SRC)) u_map (
    .clk(clk), .rst(rst), .flush(flush),
    .rd_reg(src_reg), .rd_mapped(map_hit), .rd_tag(map_tag), .rd_value(arch_val),
    .set_we(alloc_fire), .set_reg(alloc_dst), .set_tag(tail),
    .ret_we(ret_fire), .ret_reg(head_dst), .ret_tag(head), .ret_data(head_data)
  );

  rob_entry_store #(.DEPTH(DEPTH), .XLEN(XLEN), .RW(RW), .NRD(NUM_SRC)) u_slots (
    .clk(clk), .rst(rst),
    .alloc_we(alloc_fire), .alloc_idx(tail), .alloc_dst(alloc_dst),
    .wb_we(wb_fire), .wb_idx(wb_tag), .wb_data(wb_data),
    .head_idx(head), .head_done(head_done), .head_dst(head_dst), .head_data(head_data),
    .q_idx(map_tag), .q_done(slot_done), .q_data(slot_data)
  );

  // operand resolution, one copy per source
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_comb begin
      if (!map_hit[s])                          op_kind[s] = SRC_COMMITTED;
      else if (slot_done[s])                    op_kind[s] = SRC_SLOT;
      else if (wb_fire && wb_tag == map_tag[s]) op_kind[s] = SRC_BYPASS;
      else                                      op_kind[s] = SRC_PENDING;
    end
    always_comb begin
      unique case (op_kind[s])
        SRC_COMMITTED: begin op_rdy[s] = 1'b1; op_val[s] = arch_val[s];          end
        SRC_SLOT:      begin op_rdy[s] = 1'b1; op_val[s] = slot_data[s];         end
        SRC_BYPASS:    begin op_rdy[s] = 1'b1; op_val[s] = wb_data;              end
        default:       begin op_rdy[s] = 1'b0; op_val[s] = XLEN'(map_tag[s]);    end
      endcase
    end
  end

  // pointers and occupancy
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire) tail <= bump(tail);
      if (ret_fire)   head <= bump(head);
      case ({alloc_fire, ret_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // registered response and retire outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_ack    <= 1'b0;
      alloc_tag    <= '0;
      src0_ready   <= 1'b0;
      src0_val     <= '0;
      src1_ready   <= 1'b0;
      src1_val     <= '0;
      retire_valid <= 1'b0;
      retire_reg   <= '0;
      retire_data  <= '0;
    end else begin
      alloc_ack    <= alloc_fire;
      retire_valid <= ret_fire;
      if (alloc_fire) begin
        alloc_tag  <= tail;
        src0_ready <= op_rdy[0];
        src0_val   <= op_val[0];
        src1_ready <= op_rdy[1];
        src1_val   <= op_val[1];
      end
      if (ret_fire) begin
        retire_reg  <= head_dst;
        retire_data <= head_data;
      end
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !alloc_ready) |=> !alloc_ack);

  // R2
  alloc_tag_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |=> (alloc_ack && alloc_tag == $past(tail)));

  // R7
  retire_order_chk: assert property (@(posedge clk) disable iff (rst)
    (rob_empty || !head_done) |=> !retire_valid);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rob_empty && !alloc_ack && !retire_valid));

  // R9
  steady_count_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && ret_fire) |=> $stable(count));
endmodule

// File: tb/sim_rob_rename.sv
module sim_rob_rename;
  localparam int D = 72;
  localparam int TW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic alloc_valid = 1'b0;
  logic [2:0] alloc_dst = '0, alloc_src0 = '0, alloc_src1 = '0;
  logic alloc_ready, alloc_ack;
  logic [TW-1:0] alloc_tag;
  logic src0_ready, src1_ready;
  logic [31:0] src0_val, src1_val;
  logic wb_valid = 1'b0;
  logic [TW-1:0] wb_tag = '0;
  logic [31:0] wb_data = '0;
  logic retire_valid;
  logic [2:0] retire_reg;
  logic [31:0] retire_data;
  logic rob_empty;

  always #10 clk = ~clk;

  rob_rename u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model
  int m_cnt, m_head, m_tail;
  bit m_done [D];
  logic [2:0] m_dst [D];
  logic [31:0] m_data [D];
  bit m_mv [8];
  int m_mt [8];
  logic [31:0] m_arch [8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear(input bit full_reset);
    m_cnt = 0; m_head = 0; m_tail = 0;
    for (int i = 0; i < D; i++) m_done[i] = 0;
    for (int r = 0; r < 8; r++) begin
      m_mv[r] = 0;
      if (full_reset) m_arch[r] = '0;
    end
  endtask

  task automatic lookup(input logic [2:0] r, output bit rdy, output logic [31:0] v, output string req);
    int t;
    if (!m_mv[r]) begin rdy = 1; v = m_arch[r]; req = "R4"; end
    else begin
      t = m_mt[r];
      if (m_done[t]) begin rdy = 1; v = m_data[t]; req = "R6"; end
      else if (wb_valid && !flush && int'(wb_tag) == t) begin rdy = 1; v = wb_data; req = "R6"; end
      else begin rdy = 0; v = 32'(t); req = "R5"; end
    end
  endtask

  // one clock: predict, advance, compare, update model
  task automatic step();
    bit acc, ret, r0, r1;
    logic [31:0] v0, v1, rdat;
    logic [2:0] rreg;
    string q0, q1;
    int etag;
    chk(alloc_ready == (m_cnt < D), (m_cnt == D) ? "R3" : "R2", 32'(alloc_ready), 32'(m_cnt < D));
    acc = alloc_valid && (m_cnt < D) && !flush;
    ret = !flush && m_cnt > 0 && m_done[m_head];
    lookup(alloc_src0, r0, v0, q0);
    lookup(alloc_src1, r1, v1, q1);
    etag = m_tail;
    rreg = m_dst[m_head]; rdat = m_data[m_head];
    @(posedge clk); @(negedge clk);
    chk(alloc_ack == acc, (alloc_valid && m_cnt == D) ? "R3" : "R2", 32'(alloc_ack), 32'(acc));
    if (acc && alloc_ack) begin
      chk(int'(alloc_tag) == etag, "R2", 32'(alloc_tag), 32'(etag));
      chk(src0_ready == r0 && src0_val == v0, q0, src0_val, v0);
      chk(src1_ready == r1 && src1_val == v1, q1, src1_val, v1);
    end
    chk(retire_valid == ret, "R7", 32'(retire_valid), 32'(ret));
    if (ret && retire_valid)
      chk(retire_reg == rreg && retire_data == rdat, "R8", retire_data, rdat);
    if (flush) begin
      model_clear(0);
      chk(rob_empty == 1'b1, "R10", 32'(rob_empty), 1);
    end else begin
      if (ret) begin
        m_arch[rreg] = rdat;
        if (m_mv[rreg] && m_mt[rreg] == m_head) m_mv[rreg] = 0;
        m_head = (m_head + 1) % D; m_cnt--;
      end
      if (wb_valid) begin m_done[wb_tag] = 1; m_data[wb_tag] = wb_data; end
      if (acc) begin
        m_dst[m_tail] = alloc_dst; m_done[m_tail] = 0;
        m_mv[alloc_dst] = 1; m_mt[alloc_dst] = m_tail;
        m_tail = (m_tail + 1) % D; m_cnt++;
      end
      if (acc && ret) chk(alloc_ready == (m_cnt < D), "R9", 32'(alloc_ready), 32'(m_cnt < D));
    end
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; wb_valid = 0; flush = 0;
  endtask

  task automatic do_alloc(input logic [2:0] d, input logic [2:0] s0, input logic [2:0] s1);
    alloc_valid = 1; alloc_dst = d; alloc_src0 = s0; alloc_src1 = s1;
  endtask

  task automatic do_wb(input int t, input logic [31:0] v);
    wb_valid = 1; wb_tag = TW'(t); wb_data = v;
  endtask

  // watchdog
  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, pick;
    void'($urandom(32'h5eed_1234));
    model_clear(1);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(rob_empty && alloc_ready && !alloc_ack && !retire_valid, "R1", {rob_empty, alloc_ready, alloc_ack, retire_valid}, 4'b1100);
    do_alloc(3'd1, 3'd5, 3'd6); step();
    chk(src0_ready && src0_val == 0, "R1", src0_val, 0);
    // R5: consumer of pending reg 1
    do_alloc(3'd2, 3'd1, 3'd1); step();
    chk(!src0_ready && src0_val == 0, "R5", src0_val, 0);
    // R7: complete younger slot 1 first; head must not retire
    idle_inputs(); do_wb(1, 32'hAAAA_0001); step();
    idle_inputs(); step();
    chk(!retire_valid, "R7", 32'(retire_valid), 0);
    // R6: bypass of slot 0 during a consumer allocation
    idle_inputs(); do_wb(0, 32'h1234_5678); do_alloc(3'd4, 3'd1, 3'd2); step();
    chk(src0_ready && src0_val == 32'h1234_5678, "R6", src0_val, 32'h1234_5678);
    chk(src1_ready && src1_val == 32'hAAAA_0001, "R6", src1_val, 32'hAAAA_0001);
    idle_inputs(); step(); step();
    // R11: two writers of reg 3, younger completes first
    do_alloc(3'd3, 3'd0, 3'd0); step();
    base = m_tail;
    do_alloc(3'd3, 3'd0, 3'd0); step();
    idle_inputs(); do_wb(base, 32'h0000_BBBB); step();
    do_wb(m_mt[4], 32'h4444); do_alloc(3'd5, 3'd3, 3'd3); step();
    chk(src0_val == 32'h0000_BBBB, "R11", src0_val, 32'h0000_BBBB);
    idle_inputs(); do_wb(base - 1, 32'h0000_AAAA); step();
    idle_inputs(); do_wb(m_mt[5], 32'h5555); step();
    idle_inputs(); repeat (6) step();
    do_alloc(3'd6, 3'd3, 3'd7); step();
    chk(src0_ready && src0_val == 32'h0000_BBBB, "R11", src0_val, 32'h0000_BBBB);
    // R3: fill to DEPTH with no completions, then try once more
    idle_inputs();
    while (m_cnt < D) begin do_alloc(3'(m_cnt % 8), 3'd2, 3'd3); step(); end
    do_alloc(3'd0, 3'd0, 3'd0); step();
    chk(!alloc_ack && !alloc_ready, "R3", 32'(alloc_ack), 0);
    // R10: flush, including an allocation attempt in the flush cycle
    flush = 1; step();
    idle_inputs(); do_alloc(3'd0, 3'd3, 3'd1); step();
    chk(src0_ready && src0_val == m_arch[3], "R10", src0_val, m_arch[3]);
    // random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      idle_inputs();
      if ($urandom_range(99) < 60)
        do_alloc(3'($urandom_range(7)), 3'($urandom_range(7)), 3'($urandom_range(7)));
      if (m_cnt > 0 && $urandom_range(99) < 70) begin
        base = $urandom_range(m_cnt - 1);
        for (int k = 0; k < m_cnt; k++) begin
          pick = (m_head + (base + k) % m_cnt) % D;
          if (!m_done[pick]) begin do_wb(pick, $urandom); break; end
        end
      end
      if ($urandom_range(499) == 0) begin flush = 1; wb_valid = 0; end
      step();
    end
    idle_inputs();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule